// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block derives the bit timing of a CAN node from the system clock. A programmable divider turns the clock into time quanta. A three-state sequencer then steps each bit through a one-quantum synchronisation segment, a first phase segment and a second phase segment. The first phase segment also carries the signal propagation allowance. The sequencer pulses a strobe at the sampling instant, where it latches the receive line, and another strobe at the start of every bit, where the transmitter drives its next bit.

The sequencer watches the receive line for falling (recessive-to-dominant) transitions. While the bus is idle, such a transition restarts the bit at the synchronisation segment (hard synchronisation). Inside a frame, it stretches the first phase segment or trims the second, by no more than the programmed jump width. Two configuration bytes set the quantum divider, the jump width and both segment lengths. A frame-level controller drives `bus_idle` to select between the two behaviours.

Top module: `can_bit_timer`

## Requirements
- R1: While `rst` is high, `seg` is 0, `sample_pt` and `tx_pt` are low, and `rx_bit` is 1.
- R2: One time quantum lasts `cfg_rate[5:0]`+1 clock cycles, and the synchronisation segment lasts exactly one quantum.
- R3: With no falling edges on `rx`, `sample_pt` rises (Q·(`cfg_seg[3:0]`+2)) cycles after `tx_pt`, and `tx_pt` repeats every Q·(`cfg_seg[3:0]`+`cfg_seg[7:4]`+3) cycles, where Q is the quantum length in cycles.
- R4: `seg` reports the segment as 0 = synchronisation, 1 = phase one, 2 = phase two. The order is always 0, 1, 2, except that a hard synchronisation jumps to 0. `seg` never takes the value 3.
- R5: `sample_pt` is high for one cycle as phase one ends. On that same edge `rx_bit` takes the value of `rx`, and `rx_bit` changes at no other time.
- R6: `tx_pt` is high for exactly one cycle, the first cycle of every synchronisation segment.
- R7: When `bus_idle` is high, a falling edge on `rx` restarts the bit. `tx_pt` is high in the very next cycle, and timing continues from a full synchronisation segment.
- R8: When `bus_idle` is low, a falling edge seen in phase-one quantum k (counting from 0) lengthens phase one by min(k+1, J) quanta, where J = `cfg_rate[7:6]`+1.
- R9: When `bus_idle` is low, a falling edge seen in phase-two quantum j, with phase two nominally L2 = `cfg_seg[7:4]`+1 quanta, shortens phase two to max(L2 − min(L2−j, J), j+1) quanta.
- R10: Only one adjustment (R8 or R9) takes effect between two sample points. A hard synchronisation also uses up that allowance until the next sample point.
- R11: A falling edge seen during the synchronisation segment inside a frame changes neither timing nor the allowance.
- R12: An edge is `rx` high at one rising clock edge and low at the next. A rising transition of `rx` never resynchronises, even while `bus_idle` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_rate | input | 8 | [5:0] quantum divider minus one, [7:6] jump width minus one |
| cfg_seg | input | 8 | [3:0] phase-one length minus one, [7:4] phase-two length minus one |
| bus_idle | input | 1 | High selects hard synchronisation, low selects resynchronisation |
| rx | input | 1 | Receive line, 1 = recessive |
| seg | output | 2 | Current segment code |
| sample_pt | output | 1 | One-cycle strobe at the sampling instant |
| rx_bit | output | 1 | Bit value latched at the last sample point |
| tx_pt | output | 1 | One-cycle strobe at the start of each bit |

## Verification
The assertions assume that the configuration bytes stay constant between resets, and that `rx` is a clean synchronous signal. The checker rebuilds its own one-cycle edge history from `rx`, so it relies on no glitch reaching the sampling register. The stimulus changes the configuration only while `rst` is high, and it moves `rx` and `bus_idle` only on falling clock edges. Every injected edge is placed on a chosen quantum, counted from the observed `tx_pt`, so the expected lengthening or shortening follows directly from R8 and R9.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    localparam int BRP_W = 6;
    localparam int TS1_W = 4;
    localparam int TS2_W = 4;
    localparam int SJW_W = 2;
    localparam int Q_W   = TS1_W + 1;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

    typedef struct packed {
        logic [BRP_W-1:0] brp;
        logic [Q_W-1:0]   len1;
        logic [Q_W-1:0]   len2;
        logic [Q_W-1:0]   sjw;
    } bt_cfg_t;

    function automatic bt_cfg_t bt_decode(input logic [7:0] rate, input logic [7:0] segs);
        bt_cfg_t c;
        c.brp  = rate[BRP_W-1:0];
        c.sjw  = Q_W'(rate[7:6]) + Q_W'(1);
        c.len1 = Q_W'(segs[3:0]) + Q_W'(1);
        c.len2 = Q_W'(segs[7:4]) + Q_W'(1);
        return c;
    endfunction

    function automatic logic [Q_W-1:0] q_min(input logic [Q_W-1:0] a, input logic [Q_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/can_bt_tq_gen.sv
module can_bt_tq_gen #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/can_bt_edge.sv
module can_bt_edge (
    input  logic clk,
    input  logic rst,
    input  logic rx,
    output logic fall
);
    logic rx_d;

    always_ff @(posedge clk) begin
        if (rst) rx_d <= 1'b1;
        else     rx_d <= rx;
    end

    // recessive at the previous edge, dominant now
    assign fall = rx_d & ~rx;
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    fall,
    input  logic    bus_idle,
    input  logic    rx,
    input  bt_cfg_t cfg,
    output seg_e    seg,
    output logic    sample_pt,
    output logic    tx_pt,
    output logic    rx_bit,
    output logic    hsync
);
    seg_e           state;
    logic [Q_W-1:0] q_cnt;
    logic [Q_W-1:0] ext;
    logic [Q_W-1:0] shr;
    logic           rs_used;

    logic           resync_ok;
    logic [Q_W-1:0] q_nx, rem2, adj1, adj2, len1_eff, len2_eff;
    logic           end1, end2;

    always_comb begin
        hsync     = bus_idle & fall;
        resync_ok = fall & ~bus_idle & ~rs_used;
        q_nx      = q_cnt + 1'b1;
        rem2      = cfg.len2 - q_cnt;
        adj1      = (state == SEG_PH1 && resync_ok) ? q_min(q_nx, cfg.sjw) : '0;
        adj2      = (state == SEG_PH2 && resync_ok) ? q_min(rem2, cfg.sjw) : '0;
        len1_eff  = cfg.len1 + ext + adj1;
        len2_eff  = cfg.len2 - shr - adj2;
        end1      = (q_nx >= len1_eff);
        end2      = (q_nx >= len2_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEG_SYNC;
            q_cnt     <= '0;
            ext       <= '0;
            shr       <= '0;
            rs_used   <= 1'b0;
            sample_pt <= 1'b0;
            tx_pt     <= 1'b0;
            rx_bit    <= 1'b1;
        end else begin
            sample_pt <= 1'b0;
            tx_pt     <= 1'b0;
            if (hsync) begin
                state   <= SEG_SYNC;
                q_cnt   <= '0;
                ext     <= '0;
                shr     <= '0;
                rs_used <= 1'b1;
                tx_pt   <= 1'b1;
            end else begin
                if (resync_ok && state != SEG_SYNC) begin
                    rs_used <= 1'b1;
                    if (state == SEG_PH1) ext <= adj1;
                    else                  shr <= adj2;
                end
                if (tick) begin
                    case (state)
                        SEG_SYNC: begin
                            state <= SEG_PH1;
                            q_cnt <= '0;
                        end
                        SEG_PH1: begin
                            if (end1) begin
                                state     <= SEG_PH2;
                                q_cnt     <= '0;
                                ext       <= '0;
                                rs_used   <= 1'b0;
                                sample_pt <= 1'b1;
                                rx_bit    <= rx;
                            end else begin
                                q_cnt <= q_nx;
                            end
                        end
                        SEG_PH2: begin
                            if (end2) begin
                                state <= SEG_SYNC;
                                q_cnt <= '0;
                                shr   <= '0;
                                tx_pt <= 1'b1;
                            end else begin
                                q_cnt <= q_nx;
                            end
                        end
                        default: begin
                            state <= SEG_SYNC;
                            q_cnt <= '0;
                        end
                    endcase
                end
            end
        end
    end

    assign seg = state;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cfg_rate,
    input  logic [7:0] cfg_seg,
    input  logic       bus_idle,
    input  logic       rx,
    output logic [1:0] seg,
    output logic       sample_pt,
    output logic       rx_bit,
    output logic       tx_pt
);
    bt_cfg_t cfg;
    logic    fall, tick, restart;
    seg_e    seg_q;

    assign cfg = bt_decode(cfg_rate, cfg_seg);

    can_bt_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .rx   (rx),
        .fall (fall)
    );

    can_bt_tq_gen #(.W(BRP_W)) u_tq (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .limit   (cfg.brp),
        .tick    (tick)
    );

    can_bt_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .fall      (fall),
        .bus_idle  (bus_idle),
        .rx        (rx),
        .cfg       (cfg),
        .seg       (seg_q),
        .sample_pt (sample_pt),
        .tx_pt     (tx_pt),
        .rx_bit    (rx_bit),
        .hsync     (restart)
    );

    assign seg = seg_q;
endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx,
    input logic       bus_idle,
    input logic [1:0] seg,
    input logic       sample_pt,
    input logic       rx_bit,
    input logic       tx_pt
);
    logic rx_prev;

    always_ff @(posedge clk) begin
        if (rst) rx_prev <= 1'b1;
        else     rx_prev <= rx;
    end

    assert_seg_legal_R4: assert property (@(posedge clk) disable iff (rst)
        seg != 2'd3);

    assert_sync_not_to_ph2_R4: assert property (@(posedge clk) disable iff (rst)
        seg == 2'd0 |=> seg != 2'd2);

    assert_ph2_not_to_ph1_R4: assert property (@(posedge clk) disable iff (rst)
        seg == 2'd2 |=> seg != 2'd1);

    assert_sample_in_ph2_R5: assert property (@(posedge clk) disable iff (rst)
        sample_pt |-> seg == 2'd2);

    assert_sample_single_R5: assert property (@(posedge clk) disable iff (rst)
        sample_pt |=> !sample_pt);

    assert_rxbit_only_at_sample_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_bit != $past(rx_bit)) |-> sample_pt);

    assert_tx_in_sync_R6: assert property (@(posedge clk) disable iff (rst)
        tx_pt |-> seg == 2'd0);

    assert_strobes_disjoint_R6: assert property (@(posedge clk) disable iff (rst)
        !(tx_pt && sample_pt));

    assert_hard_sync_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_idle && rx_prev && !rx) |=> tx_pt);
endmodule

bind can_bit_timer can_bt_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx        (rx),
    .bus_idle  (bus_idle),
    .seg       (seg),
    .sample_pt (sample_pt),
    .rx_bit    (rx_bit),
    .tx_pt     (tx_pt)
);

// File: tb/sim_can_bit_timer.sv
`timescale 1ns/1ps
module sim_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_rate = 8'h00;
    logic [7:0] cfg_seg  = 8'h00;
    logic       bus_idle = 1'b0;
    logic       rx = 1'b1;
    logic [1:0] seg;
    logic       sample_pt, rx_bit, tx_pt;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    can_bit_timer u0 (
        .clk(clk), .rst(rst), .cfg_rate(cfg_rate), .cfg_seg(cfg_seg),
        .bus_idle(bus_idle), .rx(rx), .seg(seg), .sample_pt(sample_pt),
        .rx_bit(rx_bit), .tx_pt(tx_pt)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int brp, input int ts1, input int ts2, input int sjwf);
        rst      = 1'b1;
        rx       = 1'b1;
        bus_idle = 1'b0;
        cfg_rate = {sjwf[1:0], brp[5:0]};
        cfg_seg  = {ts2[3:0], ts1[3:0]};
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Waits for a bit start, then follows one bit; rx events are driven at
    // the given negedge offsets counted from the observed tx_pt (-1 = none).
    task automatic bit_run(input int f1, input int r1, input int f2, input int r2,
                           output int ts, output int tt, output int sl,
                           output int rb, output int ss, output int spc);
        int guard = 0;
        ts = -1; tt = -1; sl = -1; rb = -1; ss = -1; spc = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!tx_pt && guard < 2000);
        for (int n = 0; n < 600; n++) begin
            if (n > 0) begin
                @(negedge clk);
                if (tx_pt) begin
                    tt = n;
                    break;
                end
            end
            if (sl < 0 && seg != 2'd0) sl = n;
            if (sample_pt) begin
                if (ts < 0) begin
                    ts = n;
                    rb = int'(rx_bit);
                    ss = int'(seg);
                end
                spc++;
            end
            if (n == f1) rx = 1'b0;
            if (n == r1) rx = 1'b1;
            if (n == f2) rx = 1'b0;
            if (n == r2) rx = 1'b1;
        end
    endtask

    initial begin
        int ts, tt, sl, rb, ss, spc;
        int q, l1, l2;

        // Sweep: R1, R2, R3, R4, R5, R6 over brp 0..2, phase lengths 1..8
        for (int b = 0; b < 3; b++) begin
            for (int t1 = 0; t1 < 8; t1++) begin
                for (int t2 = 0; t2 < 8; t2++) begin
                    set_cfg(b, t1, t2, 1);
                    if (b == 0 && t2 == 0) begin
                        chk("R1 seg", int'(seg), 0);
                        chk("R1 sample_pt", int'(sample_pt), 0);
                        chk("R1 tx_pt", int'(tx_pt), 0);
                        chk("R1 rx_bit", int'(rx_bit), 1);
                    end
                    q = b + 1; l1 = t1 + 1; l2 = t2 + 1;
                    bit_run(-1, -1, -1, -1, ts, tt, sl, rb, ss, spc);
                    chk("R2 sync length", sl, q);
                    chk("R3 sample offset", ts, q * (1 + l1));
                    chk("R3 bit period", tt, q * (1 + l1 + l2));
                    chk("R4 seg at sample", ss, 2);
                    chk("R5 sample pulse count", spc, 1);
                    chk("R5 rx_bit", rb, 1);
                end
            end
        end

        // Directed: Q=2, phase one 6, phase two 4, jump width 3
        set_cfg(1, 5, 3, 2);

        bit_run(2, 3, -1, -1, ts, tt, sl, rb, ss, spc);      // R8 k=0
        chk("R8 lengthen k0 sample", ts, 16);
        chk("R8 lengthen k0 period", tt, 24);
        bit_run(10, 11, -1, -1, ts, tt, sl, rb, ss, spc);    // R8 k=4 clamped
        chk("R8 lengthen clamp sample", ts, 20);
        chk("R8 lengthen clamp period", tt, 28);

        bit_run(14, 15, -1, -1, ts, tt, sl, rb, ss, spc);    // R9 j=0
        chk("R9 shorten j0 sample", ts, 14);
        chk("R9 shorten j0 period", tt, 16);
        bit_run(16, 17, -1, -1, ts, tt, sl, rb, ss, spc);    // R9 j=1
        chk("R9 shorten j1 period", tt, 18);
        bit_run(18, 19, -1, -1, ts, tt, sl, rb, ss, spc);    // R9 j=2
        chk("R9 shorten j2 period", tt, 20);

        bit_run(2, 3, 8, 9, ts, tt, sl, rb, ss, spc);        // R10 second edge ignored
        chk("R10 second PH1 edge sample", ts, 16);
        chk("R10 second PH1 edge period", tt, 24);
        bit_run(2, 3, 16, 17, ts, tt, sl, rb, ss, spc);      // R10 allowance renewed
        chk("R10 renewed after sample", tt, 18);

        bit_run(0, 1, 6, 7, ts, tt, sl, rb, ss, spc);        // R11 edge in sync
        chk("R11 sync edge then PH1 edge sample", ts, 20);
        chk("R11 sync edge then PH1 edge period", tt, 28);

        // R7 hard sync, R10 allowance consumed by it, R5 captured value
        bus_idle = 1'b1;
        begin
            int guard = 0;
            do begin
                @(negedge clk);
                guard++;
            end while (!tx_pt && guard < 2000);
        end
        repeat (5) @(negedge clk);
        rx = 1'b0;
        @(negedge clk);
        chk("R7 tx_pt after idle edge", int'(tx_pt), 1);
        bus_idle = 1'b0;
        ts = -1; tt = -1; rb = -1;
        for (int n = 1; n < 600; n++) begin
            @(negedge clk);
            if (tx_pt) begin
                tt = n;
                break;
            end
            if (sample_pt && ts < 0) begin
                ts = n;
                rb = int'(rx_bit);
            end
            if (n == 1) rx = 1'b1;
            if (n == 4) rx = 1'b0;
        end
        chk("R7 sample after hard sync", ts, 14);
        chk("R10 edge after hard sync ignored", tt, 22);
        chk("R5 rx_bit captured dominant", rb, 0);

        // R12 rising transition while idle: no restart
        bus_idle = 1'b1;
        bit_run(-1, 5, -1, -1, ts, tt, sl, rb, ss, spc);
        chk("R12 rising edge sample", ts, 14);
        chk("R12 rising edge period", tt, 22);
        chk("R12 rx_bit after rise", rb, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule